// File: doc/BRIEF.md
# PCM Highway Frame and Bit Timing Recovery

This block recovers frame and bit timing for a serial PCM highway. It runs in one fast system-clock domain. It receives the highway data clock and the external frame-sync line as plain inputs, and passes each through a two-flop synchronizer. A small configuration register holds three settings: the port-count mode, single or double clock rate, and the data-clock edge on which frame sync is sampled.

Downstream port logic receives three things from the block: a single-cycle internal frame-start pulse, a single-cycle bit-enable strobe, and a bit counter that restarts at each frame. A frame begins only on a low-to-high transition of the sampled frame sync. In double-clock mode, each bit spans two data-clock periods, and bit boundaries are realigned at every frame start. The block also reports how many PCM ports the selected mode provides, and raises a flag when the stored setting is not allowed.

Top module: `pcm_sync_frontend`

## Requirements
- R1: After reset the configuration register reads 8'h00, and frame_start and bit_en are low with bit_cnt at zero.
- R2: A write with cfg_we stores cfg_wdata[3:0]. Field [1:0] is the port mode, bit 2 selects double clock rate, and bit 3 selects sampling on the rising data-clock edge. The register reads back in cfg_rdata[3:0], and cfg_rdata[7:4] always reads zero.
- R3: ports_active is 4 for mode code 0, 2 for code 1, 1 for code 2 and 0 for the undefined code 3.
- R4: cfg_illegal is high exactly when the mode code is 3, or when the mode code is 2 with double clock rate selected.
- R5: With bit 3 at 0, frame sync is sampled on each falling data-clock edge. A sampled rising transition produces frame_start on the next rising data-clock edge.
- R6: With bit 3 at 1, frame sync is sampled on each rising data-clock edge. A sampled rising transition produces frame_start on that same rising edge.
- R7: Only a low-to-high transition of the sampled frame sync starts a frame. Frame sync held high for many data-clock periods yields exactly one frame_start.
- R8: At single clock rate, bit_en pulses once for every rising data-clock edge.
- R9: At double clock rate, bit_en pulses on the frame-start rising edge and then on every second rising edge after it.
- R10: bit_cnt is zero in the cycle frame_start is high. It increases by one with each other bit_en pulse and holds its value otherwise. frame_start is always accompanied by bit_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| dclk_in | input | 1 | Highway data clock, asynchronous |
| fsync_in | input | 1 | External frame sync, asynchronous |
| frame_start | output | 1 | Internal frame-start pulse, one cycle |
| bit_en | output | 1 | Bit-enable strobe, one cycle |
| bit_cnt | output | CNT_W | Bit position within the frame |
| ports_active | output | 3 | Number of PCM ports in the selected mode |
| cfg_illegal | output | 1 | Illegal configuration flag |

## Verification
A frame start always falls on a rising data-clock edge that also produces a bit enable. In that cycle the counter must clear rather than advance. The bench provokes this in every mode by raising frame sync in a chosen low phase of the data clock. It then judges that the counter reads zero exactly when frame_start is seen, and that the last counted bit equals the number of enables minus one. A second coincidence appears in double-clock mode, where the frame start must also realign the divide-by-two phase. This is judged by the index of every enabled rising edge counted from the start.

// File: rtl/pcm_sync_frontend.sv
module pcm_sync_frontend #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             dclk_in,
  input  logic             fsync_in,
  output logic             frame_start,
  output logic             bit_en,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [2:0]       ports_active,
  output logic             cfg_illegal
);

  logic [3:0] cfg_q;
  logic [2:0] dclk_sr;
  logic [1:0] fs_sr;
  logic       fs_smp, fs_pend, phase;

  wire [1:0] mode   = cfg_q[1:0];
  wire       dbl    = cfg_q[2];
  wire       srise  = cfg_q[3];
  wire       rise   = dclk_sr[1] & ~dclk_sr[2];
  wire       fall   = ~dclk_sr[1] & dclk_sr[2];
  wire       fs_now = fs_sr[1];

  wire start_cond = srise ? (fs_now & ~fs_smp) : fs_pend;
  wire en_now     = start_cond | ~dbl | ~phase;

  assign cfg_rdata   = {4'b0, cfg_q};
  assign cfg_illegal = (mode == 2'd3) | ((mode == 2'd2) & dbl);

  always_comb begin
    case (mode)
      2'd0:    ports_active = 3'd4;
      2'd1:    ports_active = 3'd2;
      2'd2:    ports_active = 3'd1;
      default: ports_active = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      dclk_sr     <= '0;
      fs_sr       <= '0;
      fs_smp      <= 1'b0;
      fs_pend     <= 1'b0;
      phase       <= 1'b0;
      frame_start <= 1'b0;
      bit_en      <= 1'b0;
      bit_cnt     <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata[3:0];
      dclk_sr     <= {dclk_sr[1:0], dclk_in};
      fs_sr       <= {fs_sr[0], fsync_in};
      frame_start <= 1'b0;
      bit_en      <= 1'b0;
      if (rise) begin
        frame_start <= start_cond;
        bit_en      <= en_now;
        phase       <= en_now;
        fs_pend     <= 1'b0;
        if (srise) fs_smp <= fs_now;
        if (en_now) bit_cnt <= start_cond ? '0 : bit_cnt + 1'b1;
      end
      if (fall && !srise) begin
        fs_pend <= fs_now & ~fs_smp;
        fs_smp  <= fs_now;
      end
    end
  end

endmodule

module pcm_sync_frontend_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       cfg_rdata,
  input logic             frame_start,
  input logic             bit_en,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [2:0]       ports_active,
  input logic             cfg_illegal
);

  // R10
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bit_en && bit_cnt == '0));

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !frame_start) |-> (bit_cnt == CNT_W'($past(bit_cnt) + 1'b1)));

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> $stable(bit_cnt));

  // R4
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal == ((cfg_rdata[1:0] == 2'd3) || (cfg_rdata[1:0] == 2'd2 && cfg_rdata[2])));

  // R3
  ports_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ports_active == 3'd0) == (cfg_rdata[1:0] == 2'd3));

  // R2
  rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:4] == 4'd0);

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

endmodule

bind pcm_sync_frontend pcm_sync_frontend_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
  .bit_en(bit_en), .bit_cnt(bit_cnt), .ports_active(ports_active),
  .cfg_illegal(cfg_illegal)
);

// File: tb/tb_pcm_sync_frontend.sv
module tb_pcm_sync_frontend;
  localparam int CNT_W = 10;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, dclk_in = 1'b0, fsync_in = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic frame_start, bit_en, cfg_illegal;
  logic [CNT_W-1:0] bit_cnt;
  logic [2:0] ports_active;

  int checks = 0, errors = 0;
  int starts, start_idx, nbits, last_cnt, cnt_at_start;

  always #2 clk = ~clk;

  pcm_sync_frontend #(.CNT_W(CNT_W)) dut (.*);

  // {mode[1:0], dbl, srise, ill, ports[2:0], start_rise[2:0], nbits[2:0]}
  localparam logic [13:0] VEC [7] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 3'd4, 3'd3, 3'd5},
    {2'd0, 1'b0, 1'b1, 1'b0, 3'd4, 3'd2, 3'd6},
    {2'd1, 1'b1, 1'b0, 1'b0, 3'd2, 3'd3, 3'd3},
    {2'd1, 1'b1, 1'b1, 1'b0, 3'd2, 3'd2, 3'd3},
    {2'd2, 1'b0, 1'b1, 1'b0, 3'd1, 3'd2, 3'd6},
    {2'd2, 1'b1, 1'b0, 1'b1, 3'd1, 3'd3, 3'd3},
    {2'd3, 1'b0, 1'b0, 1'b1, 3'd0, 3'd3, 3'd5}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic low_half(input bit raise_fs);
    dclk_in = 1'b0;
    repeat (2) @(negedge clk);
    if (raise_fs) fsync_in = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic high_half(input int r);
    dclk_in = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (frame_start) begin
        starts++;
        start_idx = r;
        cnt_at_start = int'(bit_cnt);
      end
      if (bit_en && start_idx >= 0) begin
        nbits++;
        last_cnt = int'(bit_cnt);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", int'(cfg_rdata), 0);
    check("R1 frame_start", int'(frame_start), 0);
    check("R1 bit_en", int'(bit_en), 0);
    check("R1 bit_cnt", int'(bit_cnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: readback, upper bits read zero; code 3 is illegal and has no ports
    wr(8'hFF);
    check("R2 readback", int'(cfg_rdata), 8'h0F);
    check("R4 code3 illegal", int'(cfg_illegal), 1);
    check("R3 code3 ports", int'(ports_active), 0);
    wr(8'h06);
    check("R2 readback", int'(cfg_rdata), 8'h06);
    check("R4 mode2 double illegal", int'(cfg_illegal), 1);

    for (int v = 0; v < 7; v++) begin
      logic [13:0] e;
      e = VEC[v];
      wr({4'b0, e[12], e[11], e[13], e[13]} & 8'h0F | {4'b0, e[10], e[11], e[13:12]});
      wr({4'b0, e[10], e[11], e[13:12]});
      fsync_in = 1'b0;
      repeat (2) begin low_half(1'b0); dclk_in = 1'b1; repeat (4) @(negedge clk); end
      starts = 0; start_idx = -1; nbits = 0; last_cnt = -1; cnt_at_start = -1;
      for (int r = 0; r < 8; r++) begin
        low_half(r == 2);
        high_half(r);
      end
      // R5/R6: edge on which the frame starts; R7: one start while held high
      check($sformatf("R4 v%0d illegal", v), int'(cfg_illegal), int'(e[9]));
      check($sformatf("R3 v%0d ports", v), int'(ports_active), int'(e[8:6]));
      check(e[10] ? $sformatf("R6 v%0d start rise", v) : $sformatf("R5 v%0d start rise", v),
            start_idx, int'(e[5:3]));
      check($sformatf("R7 v%0d start count", v), starts, 1);
      check(e[11] ? $sformatf("R9 v%0d bit enables", v) : $sformatf("R8 v%0d bit enables", v),
            nbits, int'(e[2:0]));
      check($sformatf("R10 v%0d count at start", v), cnt_at_start, 0);
      check($sformatf("R10 v%0d last count", v), last_cnt, int'(e[2:0]) - 1);
    end

    // R7/R10: a second frame restarts the counter
    wr(8'h08);
    fsync_in = 1'b0;
    repeat (3) begin low_half(1'b0); dclk_in = 1'b1; repeat (4) @(negedge clk); end
    starts = 0; start_idx = -1; nbits = 0; last_cnt = -1; cnt_at_start = -1;
    for (int r = 0; r < 4; r++) begin low_half(r == 1); high_half(r); end
    check("R10 restart count", cnt_at_start, 0);
    check("R7 restart single", starts, 1);
    check("R10 restart last", last_cnt, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule